// File: doc/BRIEF.md
# GCR Telemetry Frame Decoder

This block recovers one telemetry reply from a motor controller line after the line has turned around from output to input. It watches an oversampled copy of the line and measures how many sample clocks pass between successive transitions, in either direction. Each measured gap is rounded to a whole number of reply bit periods. The resulting run lengths rebuild a 21-bit transition word. The lower 20 bits of that word are read as four 5-bit group codes. Each code maps to a nibble, and the resulting 16-bit word is accepted only if its nibble checksum is correct. The block then outputs the 12-bit payload, or a fixed invalid code. It does not interpret the payload.

A controller pulses `start_i` when the reply window opens and `win_end_i` when the window closes. Between the two strobes, the first transition seen is the timing reference, and every later transition closes a run. `spb_i` sets the number of line samples per reply bit. The result leaves on a valid/ready stream. A result stays on the port, unchanged, until `res_ready_i` accepts it. The line cannot be paused, so the block does not stall: a window that closes while an earlier result is still waiting is discarded, and the waiting result is kept.

Top module: `gcr_tlm_decoder`

## Requirements
- R1: While reset is held and after it is released, `res_valid_o` is 0 until a window has been closed.
- R2: Line transitions of both polarities count, after a two-stage synchronizer. The first transition after `start_i` is only the timing reference. Transitions seen while no window is open have no effect on the next frame.
- R3: For a gap of N sample clocks between transitions, the run length is floor((N + floor(spb_i/2)) / spb_i). Gaps that are off by a sample or two from a bit multiple still decode exactly, for any spb_i >= 1, including odd values.
- R4: A gap that rounds to a run length of zero marks the frame invalid.
- R5: Runs are added only while fewer than 21 bits have been collected. Transitions after the bit count reaches 21 are ignored. A frame whose edges fill exactly 21 bits gets no padding run.
- R6: When the window closes with fewer than 21 bits collected, a final run of (21 - bits) is appended. A frame whose total passes 21, or that has no transitions, is invalid.
- R7: Bits [4:0] of the word give nibble 0, bits [9:5] give nibble 1, bits [14:10] give nibble 2 and bits [19:15] give nibble 3. The group code for each nibble is: 0:0x19, 1:0x1B, 2:0x12, 3:0x13, 4:0x1D, 5:0x15, 6:0x16, 7:0x17, 8:0x1A, 9:0x09, A:0x0A, B:0x0B, C:0x1E, D:0x0D, E:0x0E, F:0x0F. Every code not in this list decodes to 0.
- R8: A frame is valid only if the XOR of its four nibbles equals 0xF. A valid frame gives `res_ok_o`=1 and `res_data_o`={4'h0, nibbles 3..1}.
- R9: An invalid frame gives `res_ok_o`=0 and `res_data_o`=16'hFFFF.
- R10: When `win_end_i` is seen with a window open, `res_valid_o` goes high after the next rising clock edge. A `win_end_i` with no open window produces nothing. `start_i` takes priority if both strobes arrive together.
- R11: While `res_valid_o`=1 and `res_ready_i`=0, the result holds steady. A window that closes during that time is dropped.
- R12: A `start_i` while a window is already open discards everything collected so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Oversampled telemetry line |
| spb_i | input | SPB_W | Samples per reply bit (>= 1) |
| start_i | input | 1 | Opens or restarts a reply window |
| win_end_i | input | 1 | Closes the open window |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Consumer accepts result |
| res_ok_o | output | 1 | 1 = checksum good, payload valid |
| res_data_o | output | 16 | Payload zero-extended, or 16'hFFFF |

## Verification
A wrong run counter or word register shows up only when the window closes. It appears one clock after `win_end_i`, either as a shifted or misdecoded payload or as a false 16'hFFFF. The frames are therefore built so that a rounding error of one bit, a lost padding run, or a misplaced nibble changes the checksum result or the payload. A stale open/closed flag shows up at once as a result with no window, or as a missing result. A mistake in the output register shows up while `res_ready_i` is held low.

// File: rtl/gcr_tlm_pkg.sv
`timescale 1ns/1ps
package gcr_tlm_pkg;
  localparam int SYM_W      = 5;
  localparam int SYM_N      = 4;
  localparam int FRAME_BITS = SYM_W * SYM_N + 1;
  localparam int WORD_W     = 16;
  localparam logic [WORD_W-1:0] BAD_CODE = 16'hFFFF;

  function automatic logic [3:0] sym_to_nib(input logic [SYM_W-1:0] s);
    logic [3:0] n;
    case (s)
      5'h1B: n = 4'h1;  5'h12: n = 4'h2;  5'h13: n = 4'h3;
      5'h1D: n = 4'h4;  5'h15: n = 4'h5;  5'h16: n = 4'h6;
      5'h17: n = 4'h7;  5'h1A: n = 4'h8;  5'h09: n = 4'h9;
      5'h0A: n = 4'hA;  5'h0B: n = 4'hB;  5'h1E: n = 4'hC;
      5'h0D: n = 4'hD;  5'h0E: n = 4'hE;  5'h0F: n = 4'hF;
      default: n = 4'h0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/gcr_edge_sync.sv
`timescale 1ns/1ps
module gcr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/gcr_run_timer.sv
`timescale 1ns/1ps
module gcr_run_timer #(
  parameter int SPB_W = 8,
  parameter int RUN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SPB_W-1:0] spb_i,
  input  logic             restart_i,
  output logic [RUN_W-1:0] run_o
);
  logic [SPB_W-1:0] phase_q, phase_base, phase_n;
  logic [SPB_W:0]   phase_inc;
  logic [RUN_W-1:0] run_q, run_base, run_n;

  // phase starts at half a bit so that wrapping counts rounded bits
  always_comb begin
    phase_base = restart_i ? (spb_i >> 1) : phase_q;
    run_base   = restart_i ? '0 : run_q;
    phase_inc  = {1'b0, phase_base} + 1'b1;
    if (phase_inc >= {1'b0, spb_i}) begin
      phase_n = '0;
      run_n   = (run_base == '1) ? run_base : run_base + 1'b1;
    end else begin
      phase_n = phase_inc[SPB_W-1:0];
      run_n   = run_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      run_q   <= '0;
    end else begin
      phase_q <= phase_n;
      run_q   <= run_n;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/gcr_word_builder.sv
`timescale 1ns/1ps
module gcr_word_builder
  import gcr_tlm_pkg::*;
#(
  parameter int RUN_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  run_valid_i,
  input  logic [RUN_W-1:0]      run_len_i,
  output logic [FRAME_BITS-1:0] word_o,
  output logic [RUN_W-1:0]      bits_o,
  output logic                  bad_o
);
  logic [FRAME_BITS-1:0] word_q;
  logic [RUN_W-1:0]      bits_q;
  logic                  bad_q;
  logic [RUN_W:0]        bits_sum;

  assign bits_sum = {1'b0, bits_q} + {1'b0, run_len_i};

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      word_q <= '0;
      bits_q <= '0;
      bad_q  <= 1'b0;
    end else if (run_valid_i && (bits_q < RUN_W'(FRAME_BITS))) begin
      if (run_len_i == '0) begin
        bad_q <= 1'b1;
      end else begin
        word_q <= (word_q << run_len_i) | (FRAME_BITS'(1) << (run_len_i - 1'b1));
        bits_q <= bits_sum[RUN_W] ? '1 : bits_sum[RUN_W-1:0];
      end
    end
  end

  assign word_o = word_q;
  assign bits_o = bits_q;
  assign bad_o  = bad_q;
endmodule

// File: rtl/gcr_frame_check.sv
`timescale 1ns/1ps
module gcr_frame_check
  import gcr_tlm_pkg::*;
#(
  parameter int RUN_W = 6
) (
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic [RUN_W-1:0]      bits_i,
  input  logic                  bad_i,
  output logic                  ok_o,
  output logic [WORD_W-1:0]     data_o
);
  logic [FRAME_BITS-1:0] full_word;
  logic [RUN_W-1:0]      pad_len;
  logic                  len_ok;
  logic [WORD_W-1:0]     nibs;
  logic [3:0]            fold;

  always_comb begin
    pad_len = RUN_W'(FRAME_BITS) - bits_i;
    if (bits_i < RUN_W'(FRAME_BITS)) begin
      full_word = (word_i << pad_len) | (FRAME_BITS'(1) << (pad_len - 1'b1));
      len_ok    = 1'b1;
    end else begin
      full_word = word_i;
      len_ok    = (bits_i == RUN_W'(FRAME_BITS));
    end
  end

  for (genvar g = 0; g < SYM_N; g++) begin : g_sym
    assign nibs[4*g +: 4] = sym_to_nib(full_word[SYM_W*g +: SYM_W]);
  end

  always_comb begin
    fold = '0;
    for (int k = 0; k < SYM_N; k++) fold = fold ^ nibs[4*k +: 4];
  end

  assign ok_o   = len_ok && !bad_i && (fold == 4'hF);
  assign data_o = ok_o ? {4'h0, nibs[WORD_W-1:4]} : BAD_CODE;
endmodule

// File: rtl/gcr_tlm_decoder.sv
`timescale 1ns/1ps
module gcr_tlm_decoder
  import gcr_tlm_pkg::*;
#(
  parameter int SPB_W = 8,
  parameter int RUN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [SPB_W-1:0]  spb_i,
  input  logic              start_i,
  input  logic              win_end_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_ok_o,
  output logic [WORD_W-1:0] res_data_o
);
  logic edge_w, armed_q, have_ref_q;
  logic take_edge, ref_edge, run_edge, close_win, out_busy;
  logic [RUN_W-1:0]      run_len;
  logic [FRAME_BITS-1:0] word_w;
  logic [RUN_W-1:0]      bits_w;
  logic                  bad_w, ok_w;
  logic [WORD_W-1:0]     data_w;
  logic                  valid_q, ok_q;
  logic [WORD_W-1:0]     data_q;

  gcr_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .edge_o(edge_w));

  assign take_edge = armed_q && !start_i && !win_end_i && edge_w;
  assign ref_edge  = take_edge && !have_ref_q;
  assign run_edge  = take_edge && have_ref_q;
  assign close_win = armed_q && win_end_i && !start_i;
  assign out_busy  = valid_q && !res_ready_i;

  gcr_run_timer #(.SPB_W(SPB_W), .RUN_W(RUN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .spb_i(spb_i), .restart_i(take_edge), .run_o(run_len));

  gcr_word_builder #(.RUN_W(RUN_W)) u_build (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .run_valid_i(run_edge),
    .run_len_i(run_len), .word_o(word_w), .bits_o(bits_w), .bad_o(bad_w));

  gcr_frame_check #(.RUN_W(RUN_W)) u_check (
    .word_i(word_w), .bits_i(bits_w), .bad_i(bad_w), .ok_o(ok_w), .data_o(data_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      have_ref_q <= 1'b0;
    end else if (start_i) begin
      armed_q    <= 1'b1;
      have_ref_q <= 1'b0;
    end else begin
      if (close_win) armed_q    <= 1'b0;
      if (ref_edge)  have_ref_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ok_q    <= 1'b0;
      data_q  <= '0;
    end else if (close_win && !out_busy) begin
      valid_q <= 1'b1;
      ok_q    <= ok_w;
      data_q  <= data_w;
    end else if (res_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign res_valid_o = valid_q;
  assign res_ok_o    = ok_q;
  assign res_data_o  = data_q;
endmodule

// File: rtl/gcr_tlm_decoder_chk.sv
`timescale 1ns/1ps
module gcr_tlm_decoder_chk #(
  parameter int RUN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             win_end_i,
  input logic             res_ready_i,
  input logic             res_valid_o,
  input logic             res_ok_o,
  input logic [15:0]      res_data_o,
  input logic             armed_q,
  input logic             run_edge,
  input logic [RUN_W-1:0] bits_w
);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && armed_q && !start_i && !(res_valid_o && !res_ready_i)) |=> res_valid_o);

  p_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> $past(win_end_i));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_data_o) && $stable(res_ok_o)));

  p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ok_o) |-> (res_data_o == 16'hFFFF));

  p_payload_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ok_o) |-> (res_data_o[15:12] == 4'h0));

  p_bits_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((bits_w >= RUN_W'(21)) && run_edge && !start_i) |=> $stable(bits_w));
endmodule

bind gcr_tlm_decoder gcr_tlm_decoder_chk #(.RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_end_i(win_end_i),
  .res_ready_i(res_ready_i), .res_valid_o(res_valid_o), .res_ok_o(res_ok_o),
  .res_data_o(res_data_o), .armed_q(armed_q), .run_edge(run_edge), .bits_w(bits_w));

// File: tb/gcr_tlm_decoder_tb.sv
`timescale 1ns/1ps
module gcr_tlm_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_i = 1'b1;
  logic [7:0]  spb_i = 8'd8;
  logic        start_i = 1'b0;
  logic        win_end_i = 1'b0;
  logic        res_ready_i = 1'b1;
  logic        res_valid_o, res_ok_o;
  logic [15:0] res_data_o;
  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gcr_tlm_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .spb_i(spb_i), .start_i(start_i),
    .win_end_i(win_end_i), .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_ok_o(res_ok_o), .res_data_o(res_data_o));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'h19; 4'h1: return 5'h1B; 4'h2: return 5'h12; 4'h3: return 5'h13;
      4'h4: return 5'h1D; 4'h5: return 5'h15; 4'h6: return 5'h16; 4'h7: return 5'h17;
      4'h8: return 5'h1A; 4'h9: return 5'h09; 4'hA: return 5'h0A; 4'hB: return 5'h0B;
      4'hC: return 5'h1E; 4'hD: return 5'h0D; 4'hE: return 5'h0E; default: return 5'h0F;
    endcase
  endfunction

  function automatic logic [20:0] make_word(input logic [11:0] p, input bit corrupt);
    logic [3:0] k;
    k = ~(p[11:8] ^ p[7:4] ^ p[3:0]);
    if (corrupt) k = k ^ 4'h1;
    return {1'b1, enc(p[11:8]), enc(p[7:4]), enc(p[3:0]), enc(k)};
  endfunction

  task automatic open_win();
    start_i = 1'b1; step(1); start_i = 1'b0;
  endtask

  task automatic drive_frame(input logic [20:0] w, input int spb, input bit jit, input bit extra);
    int last = 0;
    int t;
    line_i = ~line_i;
    for (int p = 19; p >= 0; p--) begin
      if (w[p]) begin
        t = (20 - p) * spb + (jit ? ((p % 2 == 1) ? 1 : -1) : 0);
        step(t - last); line_i = ~line_i; last = t;
      end
    end
    if (extra) begin
      step(21 * spb - last); line_i = ~line_i;
      step(2 * spb); line_i = ~line_i;
      step(spb); line_i = ~line_i;
    end
    step(4);
  endtask

  task automatic close_check(input string req, input bit exp_ok, input logic [15:0] exp_data);
    win_end_i = 1'b1; step(1); win_end_i = 1'b0;
    check({req, " valid"}, res_valid_o, 1);
    check({req, " ok"}, res_ok_o, exp_ok);
    check({req, " data"}, res_data_o, exp_data);
    step(2);
  endtask

  task automatic good_frame(input string req, input logic [11:0] p, input int spb, input bit jit);
    spb_i = 8'(spb);
    open_win();
    drive_frame(make_word(p, 1'b0), spb, jit, 1'b0);
    close_check(req, 1'b1, {4'h0, p});
  endtask

  task automatic t_reset();
    check("R1 reset valid", res_valid_o, 0);
    rst_n = 1'b1; step(3);
    check("R1 idle valid", res_valid_o, 0);
  endtask

  task automatic t_basic();
    good_frame("R2 R8 R10 basic", 12'h3A5, 8, 1'b0);
  endtask

  task automatic t_table();
    good_frame("R7 nibbles 123", 12'h123, 6, 1'b0);
    good_frame("R7 nibbles 456", 12'h456, 6, 1'b0);
    good_frame("R7 nibbles 789", 12'h789, 6, 1'b0);
    good_frame("R7 nibbles ABC", 12'hABC, 6, 1'b0);
    good_frame("R7 nibbles DEF", 12'hDEF, 6, 1'b0);
    good_frame("R7 nibbles 000", 12'h000, 6, 1'b0);
  endtask

  task automatic t_rounding();
    good_frame("R3 odd spb", 12'hF0F, 3, 1'b0);
    good_frame("R3 jitter", 12'h5C1, 10, 1'b1);
  endtask

  task automatic t_bad_checksum();
    spb_i = 8'd8; open_win();
    drive_frame(make_word(12'h3A5, 1'b1), 8, 1'b0, 1'b0);
    close_check("R9 R8 bad checksum", 1'b0, 16'hFFFF);
  endtask

  task automatic t_overrun_and_empty();
    spb_i = 8'd4; open_win();
    line_i = ~line_i; step(25 * 4); line_i = ~line_i; step(4);
    close_check("R6 over 21 bits", 1'b0, 16'hFFFF);
    open_win(); step(6);
    close_check("R6 no edges", 1'b0, 16'hFFFF);
  endtask

  task automatic t_zero_run();
    spb_i = 8'd8; open_win();
    line_i = ~line_i; step(16);
    line_i = ~line_i; step(1); line_i = ~line_i; step(40);
    close_check("R4 zero run", 1'b0, 16'hFFFF);
  endtask

  task automatic t_extra_edges();
    spb_i = 8'd5; open_win();
    drive_frame(make_word(12'h9B4, 1'b0), 5, 1'b0, 1'b1);
    close_check("R5 exact fill and late edges", 1'b1, 16'h09B4);
  endtask

  task automatic t_idle();
    win_end_i = 1'b1; step(1); win_end_i = 1'b0;
    check("R10 close without window", res_valid_o, 0);
    line_i = ~line_i; step(3); line_i = ~line_i; step(6);
    good_frame("R2 idle edges ignored", 12'h6E2, 7, 1'b0);
  endtask

  task automatic t_restart();
    spb_i = 8'd8; open_win();
    line_i = ~line_i; step(24); line_i = ~line_i; step(13);
    line_i = ~line_i; step(6);
    good_frame("R12 restart", 12'hC37, 8, 1'b0);
  endtask

  task automatic t_backpressure();
    res_ready_i = 1'b0;
    spb_i = 8'd6; open_win();
    drive_frame(make_word(12'h111, 1'b0), 6, 1'b0, 1'b0);
    win_end_i = 1'b1; step(1); win_end_i = 1'b0;
    check("R11 first valid", res_valid_o, 1);
    step(5);
    check("R11 held data", res_data_o, 16'h0111);
    open_win();
    drive_frame(make_word(12'h222, 1'b0), 6, 1'b0, 1'b0);
    win_end_i = 1'b1; step(1); win_end_i = 1'b0;
    step(1);
    check("R11 dropped window valid", res_valid_o, 1);
    check("R11 dropped window data", res_data_o, 16'h0111);
    res_ready_i = 1'b1; step(1);
    check("R11 accepted", res_valid_o, 0);
    step(2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    step(4);
    t_reset();
    t_basic();
    t_table();
    t_rounding();
    t_bad_checksum();
    t_overrun_and_empty();
    t_zero_run();
    t_extra_edges();
    t_idle();
    t_restart();
    t_backpressure();
    finish_run();
  end

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule